// File: doc/BRIEF.md
# Contiguous Scan List Checker

This block decides whether a sequencing front end can run a requested conversion list. The front end can only step through neighbouring channels in a ring. Software gives a start pulse with the list length and the number of input channels, 16 or 32. It then streams the list in, one entry per valid cycle. Each entry carries a channel number, a gain code and a differential flag.

The checker finds the repeating segment of the list. The segment closes at the first later entry that matches entry 0 in every field. While the segment is open, each channel must follow the previous one in the ring. After a differential entry, the next channel skips one extra position, because that entry also uses its odd partner. Once the segment length is known, every later entry must copy the segment entry at the same position modulo the segment length.

One cycle after the last entry, the checker pulses done. It then reports a verdict, an error class and the index of the first failing entry. On success it also reports the segment length. Only segment entries are stored, and the repeat check runs in the same pass as the arrival of the entries.

Top module: `scan_list_checker`

## Requirements
- R1: A list of one entry is accepted with a segment length of 1.
- R2: Entry 0 is never rejected, whatever its channel or differential flag.
- R3: An entry at index 1 or above in the segment, with the differential flag set on an odd channel, is rejected with error code 1. This check takes priority over the channel step check at the same index.
- R4: Inside the segment, the expected channel for entry i is the channel of entry i-1 plus one, plus one more if entry i-1 is differential, modulo the channel count. Any other channel is rejected with error code 2.
- R5: The segment ends at the first entry at index 1 or above that equals entry 0 in channel, gain and differential flag. Its length is that index. An entry that matches entry 0 in channel only does not end the segment.
- R6: After the segment closes, entry i must equal entry (i mod segment length) in every field. Otherwise it is rejected with error code 3.
- R7: Only the first error is reported, with its index in err_idx. Later entries change nothing. On failure ok is 0 and seg_len is 0. Error code 0 means accepted.
- R8: done is high for exactly one cycle, in the cycle after the clock edge that takes the last entry. ok, err_code, err_idx and seg_len then hold until the next start.
- R9: A list that never loops back to entry 0 is accepted with a segment length equal to the list length. The channel ring wraps at 16 or at 32.
- R10: After reset, done and ok are 0 and err_code is 0.
- R11: Cycles with ent_valid low are ignored and do not advance the list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a new list; samples list_len and num_chans |
| list_len | input | 6 | Entries in the list, 1 to 32 |
| num_chans | input | 6 | Channel ring size, 16 or 32 |
| ent_valid | input | 1 | An entry is present this cycle |
| ent_chan | input | 5 | Channel number of the entry |
| ent_gain | input | 4 | Gain code of the entry |
| ent_diff | input | 1 | Entry is a differential pair |
| done | output | 1 | One-cycle pulse when the verdict is ready |
| ok | output | 1 | List can be scanned |
| err_code | output | 2 | 0 none, 1 odd differential, 2 channel gap, 3 bad repeat |
| err_idx | output | 5 | Index of the first failing entry |
| seg_len | output | 6 | Repeating segment length (0 on failure) |

## Verification
The bench targets the places where the list's meaning turns on one detail:
- An entry that matches entry 0 in channel but not in gain. A checker that compares only channels would close the segment there and accept a list that is not contiguous.
- The extra channel skip after a differential entry. An off-by-one here would reject valid paired lists or accept lists that skip a pair.
- Wrap-around at both channel counts.
- Segments of length one, where the repeat pointer must stay at zero.
- A list holding two errors, where a design that kept the last error instead of the first would report the wrong index.

Random repeated segments with single-field mutations cover the rest, and some of them are streamed with idle gaps between entries.

// File: rtl/scl_pkg.sv
package scl_pkg;

    parameter int CHAN_W = 5;
    parameter int GAIN_W = 4;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [GAIN_W-1:0] gain;
        logic              diff;
    } scl_entry_t;

    typedef enum logic [1:0] {
        SCL_NONE       = 2'd0,
        SCL_ODD_DIFF   = 2'd1,
        SCL_GAP        = 2'd2,
        SCL_BAD_REPEAT = 2'd3
    } scl_err_e;

    // Channel that must follow an entry in the ring of num channels.
    function automatic logic [CHAN_W-1:0] scl_advance(
        input logic [CHAN_W-1:0] chan,
        input logic              diff,
        input logic [CHAN_W:0]   num
    );
        logic [CHAN_W+1:0] sum;
        sum = {2'b00, chan} + (CHAN_W+2)'(1) + (CHAN_W+2)'(diff);
        if (sum >= {1'b0, num})
            sum = sum - {1'b0, num};
        return sum[CHAN_W-1:0];
    endfunction

endpackage

// File: rtl/scl_entry_buf.sv
module scl_entry_buf
    import scl_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  scl_entry_t       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output scl_entry_t       rd_data,
    output scl_entry_t       head
);

    scl_entry_t slot_w [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        scl_entry_t q;
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(g)))
                q <= wr_data;
        end
        assign slot_w[g] = q;
    end

    always_comb begin
        rd_data = slot_w[0];
        for (int k = 0; k < DEPTH; k++)
            if (rd_idx == IDX_W'(k))
                rd_data = slot_w[k];
    end

    assign head = slot_w[0];

endmodule

// File: rtl/scl_step_check.sv
module scl_step_check
    import scl_pkg::*;
(
    input  scl_entry_t        ent,
    input  scl_entry_t        head,
    input  logic [CHAN_W-1:0] exp_chan,
    input  logic [CHAN_W:0]   num_chans,
    output logic              is_loop,
    output logic              odd_diff,
    output logic              gap,
    output logic [CHAN_W-1:0] next_exp
);

    always_comb begin
        is_loop  = (ent == head);
        odd_diff = ent.diff & ent.chan[0];
        gap      = (ent.chan != exp_chan);
        next_exp = scl_advance(ent.chan, ent.diff, num_chans);
    end

endmodule

// File: rtl/scan_list_checker.sv
module scan_list_checker
    import scl_pkg::*;
#(
    parameter int MAX_LEN = 32,
    localparam int IDX_W = $clog2(MAX_LEN),
    localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LEN_W-1:0]  list_len,
    input  logic [CHAN_W:0]   num_chans,
    input  logic              ent_valid,
    input  logic [CHAN_W-1:0] ent_chan,
    input  logic [GAIN_W-1:0] ent_gain,
    input  logic              ent_diff,
    output logic              done,
    output logic              ok,
    output logic [1:0]        err_code,
    output logic [IDX_W-1:0]  err_idx,
    output logic [LEN_W-1:0]  seg_len
);

    // run state
    logic              run_q;
    logic [IDX_W-1:0]  idx_q;
    logic [LEN_W-1:0]  len_q;
    logic [CHAN_W:0]   num_q;
    logic              seg_found_q, seg_found_d;
    logic [LEN_W-1:0]  seg_len_q,   seg_len_d;
    logic [IDX_W-1:0]  rep_ptr_q,   rep_ptr_d;
    logic [CHAN_W-1:0] exp_q,       exp_d;
    scl_err_e          err_q,       err_d, cur_err;
    logic [IDX_W-1:0]  eidx_q,      eidx_d;

    // result registers
    logic              done_q, ok_q;
    scl_err_e          code_q;
    logic [IDX_W-1:0]  eidx_o_q;
    logic [LEN_W-1:0]  seg_o_q;

    scl_entry_t        ent, rd_ent, head_ent;
    logic              accept, first, last;
    logic              is_loop, odd_diff, gap;
    logic [CHAN_W-1:0] next_exp;

    assign ent    = '{chan: ent_chan, gain: ent_gain, diff: ent_diff};
    assign accept = run_q && ent_valid && !start;
    assign first  = (idx_q == '0);
    assign last   = ({1'b0, idx_q} == (len_q - LEN_W'(1)));

    scl_entry_buf #(.DEPTH(MAX_LEN)) buf_i (
        .clk     (clk),
        .wr_en   (accept && !seg_found_q),
        .wr_idx  (idx_q),
        .wr_data (ent),
        .rd_idx  (rep_ptr_q),
        .rd_data (rd_ent),
        .head    (head_ent)
    );

    scl_step_check step_i (
        .ent       (ent),
        .head      (head_ent),
        .exp_chan  (exp_q),
        .num_chans (num_q),
        .is_loop   (is_loop),
        .odd_diff  (odd_diff),
        .gap       (gap),
        .next_exp  (next_exp)
    );

    // next-state for one accepted entry
    always_comb begin
        cur_err     = SCL_NONE;
        exp_d       = exp_q;
        seg_found_d = seg_found_q;
        seg_len_d   = seg_len_q;
        rep_ptr_d   = rep_ptr_q;
        if (first) begin
            exp_d = next_exp;
        end else if (!seg_found_q) begin
            if (is_loop) begin
                seg_found_d = 1'b1;
                seg_len_d   = {1'b0, idx_q};
                rep_ptr_d   = (idx_q == IDX_W'(1)) ? '0 : IDX_W'(1);
            end else begin
                if (odd_diff)
                    cur_err = SCL_ODD_DIFF;
                else if (gap)
                    cur_err = SCL_GAP;
                exp_d = next_exp;
            end
        end else begin
            if (ent != rd_ent)
                cur_err = SCL_BAD_REPEAT;
            if (({1'b0, rep_ptr_q} + LEN_W'(1)) == seg_len_q)
                rep_ptr_d = '0;
            else
                rep_ptr_d = rep_ptr_q + IDX_W'(1);
        end
        if (err_q == SCL_NONE && cur_err != SCL_NONE) begin
            err_d  = cur_err;
            eidx_d = idx_q;
        end else begin
            err_d  = err_q;
            eidx_d = eidx_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q       <= 1'b0;
            idx_q       <= '0;
            len_q       <= '0;
            num_q       <= '0;
            seg_found_q <= 1'b0;
            seg_len_q   <= '0;
            rep_ptr_q   <= '0;
            exp_q       <= '0;
            err_q       <= SCL_NONE;
            eidx_q      <= '0;
            done_q      <= 1'b0;
            ok_q        <= 1'b0;
            code_q      <= SCL_NONE;
            eidx_o_q    <= '0;
            seg_o_q     <= '0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                run_q       <= 1'b1;
                idx_q       <= '0;
                len_q       <= list_len;
                num_q       <= num_chans;
                seg_found_q <= 1'b0;
                seg_len_q   <= '0;
                rep_ptr_q   <= '0;
                exp_q       <= '0;
                err_q       <= SCL_NONE;
                eidx_q      <= '0;
                ok_q        <= 1'b0;
                code_q      <= SCL_NONE;
                eidx_o_q    <= '0;
                seg_o_q     <= '0;
            end else if (accept) begin
                idx_q       <= idx_q + IDX_W'(1);
                exp_q       <= exp_d;
                seg_found_q <= seg_found_d;
                seg_len_q   <= seg_len_d;
                rep_ptr_q   <= rep_ptr_d;
                err_q       <= err_d;
                eidx_q      <= eidx_d;
                if (last) begin
                    run_q    <= 1'b0;
                    done_q   <= 1'b1;
                    ok_q     <= (err_d == SCL_NONE);
                    code_q   <= err_d;
                    eidx_o_q <= eidx_d;
                    if (err_d != SCL_NONE)
                        seg_o_q <= '0;
                    else if (seg_found_d)
                        seg_o_q <= seg_len_d;
                    else
                        seg_o_q <= len_q;
                end
            end
        end
    end

    assign done     = done_q;
    assign ok       = ok_q;
    assign err_code = code_q;
    assign err_idx  = eidx_o_q;
    assign seg_len  = seg_o_q;

endmodule

// File: rtl/scl_checker.sv
module scl_checker #(
    parameter int IDX_W = 5,
    parameter int LEN_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [LEN_W-1:0] list_len,
    input logic             done,
    input logic             ok,
    input logic [1:0]       err_code,
    input logic [IDX_W-1:0] err_idx,
    input logic [LEN_W-1:0] seg_len
);

    logic [LEN_W-1:0] len_cap;
    always_ff @(posedge clk) begin
        if (rst)
            len_cap <= '0;
        else if (start)
            len_cap <= list_len;
    end

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_results_hold: assert property (@(posedge clk) disable iff (rst)
        !start |=> (done || ($stable(ok) && $stable(err_code) && $stable(err_idx) && $stable(seg_len))));

    a_r7_ok_vs_code: assert property (@(posedge clk) disable iff (rst)
        done |-> (ok == (err_code == 2'd0)));

    a_r2_entry0_never_fails: assert property (@(posedge clk) disable iff (rst)
        (done && !ok) |-> (err_idx != '0));

    a_r1_single_entry: assert property (@(posedge clk) disable iff (rst)
        (done && len_cap == LEN_W'(1)) |-> (ok && seg_len == LEN_W'(1)));

    a_r9_seg_bounds: assert property (@(posedge clk) disable iff (rst)
        (done && ok) |-> (seg_len != '0 && seg_len <= len_cap));

    a_r7_err_in_list: assert property (@(posedge clk) disable iff (rst)
        (done && !ok) |-> ({1'b0, err_idx} < len_cap && seg_len == '0));

endmodule

bind scan_list_checker scl_checker #(.IDX_W(IDX_W), .LEN_W(LEN_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .list_len (list_len),
    .done     (done),
    .ok       (ok),
    .err_code (err_code),
    .err_idx  (err_idx),
    .seg_len  (seg_len)
);

// File: tb/scan_list_checker_tb_top.sv
module scan_list_checker_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [5:0] list_len = '0;
    logic [5:0] num_chans = '0;
    logic       ent_valid = 1'b0;
    logic [4:0] ent_chan = '0;
    logic [3:0] ent_gain = '0;
    logic       ent_diff = 1'b0;
    logic       done, ok;
    logic [1:0] err_code;
    logic [4:0] err_idx;
    logic [5:0] seg_len;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    int ch [32];
    int gn [32];
    int df [32];

    always #10 clk = ~clk;

    scan_list_checker dut_i (
        .clk(clk), .rst(rst), .start(start), .list_len(list_len),
        .num_chans(num_chans), .ent_valid(ent_valid), .ent_chan(ent_chan),
        .ent_gain(ent_gain), .ent_diff(ent_diff), .done(done), .ok(ok),
        .err_code(err_code), .err_idx(err_idx), .seg_len(seg_len)
    );

    task automatic chk(input string r, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
        end
    endtask

    function automatic bit same(input int a, input int b);
        return ch[a] == ch[b] && gn[a] == gn[b] && df[a] == df[b];
    endfunction

    // reference verdict from the requirements
    function automatic void model(input int len, input int nch,
                                  output int eok, output int ecode,
                                  output int eidx, output int eseg);
        int seg = len;
        int nxt;
        eok = 1; ecode = 0; eidx = 0; eseg = 0;
        nxt = ch[0];
        for (int i = 1; i < len; i++) begin
            if (same(i, 0)) begin
                seg = i;
                break;
            end
            nxt = (nxt + 1 + df[i-1]) % nch;
            if (df[i] == 1 && (ch[i] % 2) == 1) begin
                eok = 0; ecode = 1; eidx = i; return;
            end
            if (ch[i] != nxt) begin
                eok = 0; ecode = 2; eidx = i; return;
            end
        end
        for (int i = seg; i < len; i++) begin
            if (!same(i, i % seg)) begin
                eok = 0; ecode = 3; eidx = i; return;
            end
        end
        eseg = seg;
    endfunction

    task automatic set_e(input int i, input int c, input int g, input int d);
        ch[i] = c; gn[i] = g; df[i] = d;
    endtask

    task automatic run_list(input int len, input int nch, input bit gaps, input string r);
        int eok, ecode, eidx, eseg;
        @(negedge clk);
        start = 1'b1; list_len = 6'(len); num_chans = 6'(nch);
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < len; i++) begin
            if (gaps && ($urandom % 3 == 0)) begin
                ent_valid = 1'b0;
                ent_chan = 5'd31; ent_gain = 4'hF; ent_diff = 1'b1;
                @(negedge clk);
            end
            ent_valid = 1'b1;
            ent_chan = 5'(ch[i]); ent_gain = 4'(gn[i]); ent_diff = 1'(df[i]);
            @(negedge clk);
        end
        ent_valid = 1'b0;
        model(len, nch, eok, ecode, eidx, eseg);
        chk("R8", "done", int'(done), 1);
        chk(r, "ok", int'(ok), eok);
        chk(r, "err_code", int'(err_code), ecode);
        if (eok == 0) chk("R7", "err_idx", int'(err_idx), eidx);
        chk(r, "seg_len", int'(seg_len), eseg);
        @(negedge clk);
        chk("R8", "done low after pulse", int'(done), 0);
        chk("R8", "ok held", int'(ok), eok);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nerr++; nchk++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5CA1));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10", "done after reset", int'(done), 0);
        chk("R10", "ok after reset", int'(ok), 0);
        chk("R10", "code after reset", int'(err_code), 0);

        // R1 / R2: single entry, odd differential
        set_e(0, 7, 2, 1);
        run_list(1, 16, 0, "R1");
        // R2: odd differential entry 0 then step by two
        set_e(0, 3, 0, 1); set_e(1, 5, 1, 0); set_e(2, 6, 0, 0);
        run_list(3, 16, 0, "R2");
        // R9: no loop, seg = len
        for (int i = 0; i < 8; i++) set_e(i, i, i % 4, 0);
        run_list(8, 16, 0, "R9");
        // R9 / R4: wrap at 16 and 32
        set_e(0, 14, 0, 0); set_e(1, 15, 0, 0); set_e(2, 0, 0, 0); set_e(3, 1, 0, 0);
        run_list(4, 16, 0, "R9");
        set_e(0, 30, 1, 0); set_e(1, 31, 1, 0); set_e(2, 0, 1, 0);
        run_list(3, 32, 0, "R9");
        // R4: differential skip
        set_e(0, 0, 0, 1); set_e(1, 2, 0, 1); set_e(2, 4, 0, 0); set_e(3, 5, 0, 0);
        run_list(4, 16, 0, "R4");
        // R4: missing skip after differential
        set_e(0, 0, 0, 1); set_e(1, 1, 0, 0);
        run_list(2, 16, 0, "R4");
        // R4: gap
        set_e(0, 0, 0, 0); set_e(1, 1, 0, 0); set_e(2, 3, 0, 0);
        run_list(3, 16, 0, "R4");
        // R3: odd differential
        set_e(0, 0, 0, 0); set_e(1, 1, 0, 0); set_e(2, 2, 0, 0); set_e(3, 3, 0, 1);
        run_list(4, 16, 0, "R3");
        // R5: loop, seg 3
        for (int i = 0; i < 7; i++) set_e(i, 3 + (i % 3), 2, 0);
        run_list(7, 16, 0, "R5");
        // R5: channel match but gain differs is no loop
        set_e(0, 3, 0, 0); set_e(1, 4, 0, 0); set_e(2, 3, 1, 0);
        run_list(3, 16, 0, "R5");
        // R6: bad repeat
        set_e(0, 3, 0, 0); set_e(1, 4, 0, 0); set_e(2, 3, 0, 0); set_e(3, 5, 0, 0);
        run_list(4, 16, 0, "R6");
        // R6: segment of one
        for (int i = 0; i < 4; i++) set_e(i, 5, 1, 0);
        run_list(4, 16, 0, "R6");
        set_e(0, 5, 1, 0); set_e(1, 5, 1, 0); set_e(2, 6, 1, 0);
        run_list(3, 16, 0, "R6");
        // R7: two errors, first reported
        set_e(0, 0, 0, 0); set_e(1, 2, 0, 0); set_e(2, 3, 0, 1);
        run_list(3, 16, 0, "R7");
        // R5: loop at the last entry
        set_e(0, 8, 3, 0); set_e(1, 9, 3, 0); set_e(2, 8, 3, 0);
        run_list(3, 16, 0, "R5");

        // random repeated segments, some mutated, some with gaps (R11)
        for (int t = 0; t < 300; t++) begin
            int nch = ($urandom % 2) ? 32 : 16;
            int len = 1 + int'($urandom % 32);
            int seg = 1 + int'($urandom % len);
            ch[0] = int'($urandom % nch); df[0] = int'($urandom % 2); gn[0] = int'($urandom % 4);
            for (int k = 1; k < seg; k++) begin
                ch[k] = (ch[k-1] + 1 + df[k-1]) % nch;
                df[k] = (ch[k] % 2 == 0) ? int'($urandom % 2) : 0;
                gn[k] = int'($urandom % 4);
            end
            for (int k = seg; k < len; k++) set_e(k, ch[k % seg], gn[k % seg], df[k % seg]);
            if ($urandom % 2) begin
                int m = int'($urandom % len);
                case ($urandom % 3)
                    0: ch[m] = int'($urandom % nch);
                    1: gn[m] = int'($urandom % 4);
                    default: df[m] = 1 - df[m];
                endcase
            end
            run_list(len, nch, (t % 2) == 1, (t % 2) ? "R11" : "R6");
        end

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule